// File: doc/BRIEF.md
# Host-to-Audio-Coprocessor Mailbox

This block carries 16-bit words in both directions between a host processor and an audio coprocessor. Each direction owns one latched word and one ready flag. The host writes commands and reads responses. The coprocessor reads commands and writes responses. Each side can see both flags: the host through a control read and an interrupt-reason vector, the coprocessor through a status read and a set of flag inputs.

A two-bit host control register has two roles. Its value qualifies the two host interrupt reasons. When the host writes 00 to it, the coprocessor is held in reset and both ready flags are cleared. A command write also sends a one-cycle interrupt request to the coprocessor. The host and the coprocessor share a single clock. Every write and every read strobe takes effect at the rising edge.

Top module: `cmd_mailbox`

## Requirements
- R1: A host command write latches `host_cmd_data`. After that edge, `cop_cmd_data` shows the word and the command-pending flag is set. `cop_irq` is high for exactly the next cycle, unless the same edge also clears through control (R6).
- R2: A coprocessor command read clears the command-pending flag and leaves the latched word unchanged. If a command write happens at the same edge, the write wins and the flag stays set.
- R3: A coprocessor response write latches `cop_rsp_data` into `host_rsp_data` and sets the response-ready flag. A host response read clears that flag. If both happen at the same edge, the write wins.
- R4: `host_irq_reason[0]` (buffer empty) is high exactly when control equals 11 and the command-pending flag is clear. It follows flag and control changes with no further register delay.
- R5: `host_irq_reason[1]` (data ready) is high exactly when control bit 1 is set and the response-ready flag is set.
- R6: Control resets to 00, and `cop_reset` is high exactly while control is 00. A control write of 00 clears both flags, and this takes priority over any set at the same edge.
- R7: `host_ctl_rdata` has bit 1 equal to the command-pending flag and bit 0 equal to the response-ready flag.
- R8: `cop_status` has bit 7 set while a command is pending and bit 6 set while the response flag is clear. All other bits are zero.
- R9: `cop_flags` has bit 3 equal to the command-pending flag and bit 7 equal to the response-ready flag. All other bits are zero.
- R10: A command write while the command-pending flag is already set replaces the latched word, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_wr | input | 1 | Host command write strobe |
| host_cmd_data | input | 16 | Command word from host |
| host_rsp_rd | input | 1 | Host response read strobe |
| host_rsp_data | output | 16 | Latched response word |
| host_ctl_wr | input | 1 | Host control write strobe |
| host_ctl_wdata | input | 2 | New control value |
| host_ctl_rdata | output | 2 | Flags as seen by host: [1] command pending, [0] response ready |
| host_irq_reason | output | 2 | [0] buffer empty, [1] data ready |
| cop_cmd_rd | input | 1 | Coprocessor command read strobe |
| cop_cmd_data | output | 16 | Latched command word |
| cop_rsp_wr | input | 1 | Coprocessor response write strobe |
| cop_rsp_data | input | 16 | Response word from coprocessor |
| cop_status | output | 8 | [7] command pending, [6] response slot empty |
| cop_flags | output | 8 | [3] command pending, [7] response ready |
| cop_irq | output | 1 | One-cycle interrupt request after a command write |
| cop_reset | output | 1 | Holds the coprocessor in reset |

## Verification
The assertions do not assume that strobes are mutually exclusive. Any mix of writes, reads and control updates in one cycle is legal. For that reason the priority rules (write over read, control clear over both) are stated and checked directly. The stimulus draws every strobe independently from a seeded `$urandom`, so collisions come up often. Control writes favour nonzero values, so the flags have time to build up between clears. Directed steps add exact collisions, an overwrite while a command is pending, and a clear that lands on the same edge as two writes.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
    localparam int CTL_W      = 2;
    localparam int CTL_GATE_B = 1;
    localparam int STAT_W     = 8;
    localparam int ST_PEND_B  = 7;
    localparam int ST_EMPTY_B = 6;
    localparam int FL_CMD_B   = 3;
    localparam int FL_RSP_B   = 7;
    localparam int RSN_EMPTY  = 0;
    localparam int RSN_READY  = 1;
    localparam int RSN_W      = 2;

    typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    input  logic         clr,
    output logic [W-1:0] data,
    output logic         full
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         flag;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.word = wdata;
        if (clr)      st_d.flag = 1'b0;
        else if (wr)  st_d.flag = 1'b1;
        else if (rd)  st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.word;
    assign full = st_q.flag;

    assert_set_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (full && data == $past(wdata)));
    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !clr) |=> !full);
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !full);
    assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(data));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import cmd_mailbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  ctl_t ctl_wdata,
    output ctl_t ctl,
    output logic clr,
    output logic hold_reset
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d = ctl_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl        = ctl_q;
    assign clr        = ctl_wr && (ctl_wdata == '0);
    assign hold_reset = (ctl_q == '0);

    assert_reset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata == '0) |=> hold_reset);
    assert_reset_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata != '0) |=> !hold_reset);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import cmd_mailbox_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cmd_wr,
    input  logic [DATA_W-1:0] host_cmd_data,
    input  logic              host_rsp_rd,
    output logic [DATA_W-1:0] host_rsp_data,
    input  logic              host_ctl_wr,
    input  logic [1:0]        host_ctl_wdata,
    output logic [1:0]        host_ctl_rdata,
    output logic [1:0]        host_irq_reason,
    input  logic              cop_cmd_rd,
    output logic [DATA_W-1:0] cop_cmd_data,
    input  logic              cop_rsp_wr,
    input  logic [DATA_W-1:0] cop_rsp_data,
    output logic [7:0]        cop_status,
    output logic [7:0]        cop_flags,
    output logic              cop_irq,
    output logic              cop_reset
);
    ctl_t ctl;
    logic clr, cmd_full, rsp_full;
    logic irq_d, irq_q;

    mbox_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(host_ctl_wr), .ctl_wdata(host_ctl_wdata),
        .ctl(ctl), .clr(clr), .hold_reset(cop_reset)
    );

    mbox_slot #(.W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr(host_cmd_wr), .wdata(host_cmd_data),
        .rd(cop_cmd_rd), .clr(clr), .data(cop_cmd_data), .full(cmd_full)
    );

    mbox_slot #(.W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .wr(cop_rsp_wr), .wdata(cop_rsp_data),
        .rd(host_rsp_rd), .clr(clr), .data(host_rsp_data), .full(rsp_full)
    );

    always_comb begin
        irq_d = host_cmd_wr && !clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end
    assign cop_irq = irq_q;

    always_comb begin
        host_irq_reason            = '0;
        host_irq_reason[RSN_EMPTY] = (ctl == 2'b11) && !cmd_full;
        host_irq_reason[RSN_READY] = ctl[CTL_GATE_B] && rsp_full;
        host_ctl_rdata             = {cmd_full, rsp_full};
        cop_status                 = '0;
        cop_status[ST_PEND_B]      = cmd_full;
        cop_status[ST_EMPTY_B]     = !rsp_full;
        cop_flags                  = '0;
        cop_flags[FL_CMD_B]        = cmd_full;
        cop_flags[FL_RSP_B]        = rsp_full;
    end

    assert_irq_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |-> cop_status[ST_PEND_B]);
    assert_irq_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq && !host_cmd_wr |=> !cop_irq);
    assert_empty_reason_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_reason[RSN_EMPTY] |-> (!cop_reset && !cop_flags[FL_CMD_B]));
    assert_ready_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_reason[RSN_READY] |-> (host_ctl_rdata[0] && !cop_status[ST_EMPTY_B]));
    assert_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_wr && !clr && cop_status[ST_PEND_B]) |=> cop_flags[FL_CMD_B]);
    assert_write_beats_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_rsp_wr && host_rsp_rd && !clr) |=> host_ctl_rdata[0]);
endmodule

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cmd_wr = 0, host_rsp_rd = 0, host_ctl_wr = 0, cop_cmd_rd = 0, cop_rsp_wr = 0;
    logic [15:0] host_cmd_data = 0, cop_rsp_data = 0;
    logic [1:0] host_ctl_wdata = 0;
    logic [15:0] host_rsp_data, cop_cmd_data;
    logic [1:0] host_ctl_rdata, host_irq_reason;
    logic [7:0] cop_status, cop_flags;
    logic cop_irq, cop_reset;

    int total = 0, bad = 0;
    bit done = 0;

    logic [1:0] m_ctl = 0;
    logic m_cf = 0, m_rf = 0, m_irq = 0;
    logic [15:0] m_cw = 0, m_rw = 0;

    always #4 clk = ~clk;

    cmd_mailbox uut (.*);

    function automatic logic [1:0] exp_reason(logic [1:0] c, logic cf, logic rf);
        return {c[1] & rf, (c == 2'b11) & ~cf};
    endfunction
    function automatic logic [7:0] exp_status(logic cf, logic rf);
        logic [7:0] s = '0;
        s[7] = cf; s[6] = ~rf;
        return s;
    endfunction
    function automatic logic [7:0] exp_flags(logic cf, logic rf);
        logic [7:0] s = '0;
        s[3] = cf; s[7] = rf;
        return s;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1 cop_cmd_data", 32'(cop_cmd_data), 32'(m_cw));
        chk("R1 cop_irq", 32'(cop_irq), 32'(m_irq));
        chk("R3 host_rsp_data", 32'(host_rsp_data), 32'(m_rw));
        chk("R4/R5 reason", 32'(host_irq_reason), 32'(exp_reason(m_ctl, m_cf, m_rf)));
        chk("R6 cop_reset", 32'(cop_reset), 32'(m_ctl == 2'b00));
        chk("R7 host_ctl_rdata", 32'(host_ctl_rdata), 32'({m_cf, m_rf}));
        chk("R8 cop_status", 32'(cop_status), 32'(exp_status(m_cf, m_rf)));
        chk("R9 cop_flags", 32'(cop_flags), 32'(exp_flags(m_cf, m_rf)));
    endtask

    // Inputs are already driven (set after a negedge); advance one edge, update model, check.
    task automatic tick();
        logic clr;
        @(posedge clk);
        clr = host_ctl_wr && (host_ctl_wdata == 2'b00);
        if (host_ctl_wr) m_ctl = host_ctl_wdata;
        if (host_cmd_wr) m_cw = host_cmd_data;
        if (cop_rsp_wr) m_rw = cop_rsp_data;
        if (clr) m_cf = 0; else if (host_cmd_wr) m_cf = 1; else if (cop_cmd_rd) m_cf = 0;
        if (clr) m_rf = 0; else if (cop_rsp_wr) m_rf = 1; else if (host_rsp_rd) m_rf = 0;
        m_irq = host_cmd_wr && !clr;
        @(negedge clk);
        check_all();
        {host_cmd_wr, host_rsp_rd, host_ctl_wr, cop_cmd_rd, cop_rsp_wr} = '0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all(); // reset state: R6 reset held, R8 status 0x40

        // R6 release, R4 buffer-empty with ctl=11
        host_ctl_wr = 1; host_ctl_wdata = 2'b11; tick();
        chk("R4 empty reason", 32'(host_irq_reason[0]), 32'd1);
        // R1 command write
        host_cmd_wr = 1; host_cmd_data = 16'hA5C3; tick();
        chk("R1 irq pulse", 32'(cop_irq), 32'd1);
        // R10 overwrite while pending
        host_cmd_wr = 1; host_cmd_data = 16'h1234; tick();
        chk("R10 overwrite word", 32'(cop_cmd_data), 32'h1234);
        tick();
        chk("R1 irq one cycle", 32'(cop_irq), 32'd0);
        // R2 collision write+read: write wins
        host_cmd_wr = 1; cop_cmd_rd = 1; host_cmd_data = 16'h0F0F; tick();
        chk("R2 collision flag", 32'(cop_status[7]), 32'd1);
        // R2 read clears
        cop_cmd_rd = 1; tick();
        chk("R2 read clears", 32'(cop_flags[3]), 32'd0);
        // R3 response and R5 ready
        cop_rsp_wr = 1; cop_rsp_data = 16'hBEEF; tick();
        chk("R5 ready reason", 32'(host_irq_reason[1]), 32'd1);
        host_ctl_wr = 1; host_ctl_wdata = 2'b01; tick();
        chk("R5 gated off", 32'(host_irq_reason[1]), 32'd0);
        host_ctl_wr = 1; host_ctl_wdata = 2'b10; tick();
        chk("R4 needs both bits", 32'(host_irq_reason[0]), 32'd0);
        cop_rsp_wr = 1; host_rsp_rd = 1; cop_rsp_data = 16'h7777; tick();
        chk("R3 collision", 32'(host_ctl_rdata[0]), 32'd1);
        host_rsp_rd = 1; tick();
        chk("R3 read clears", 32'(host_ctl_rdata[0]), 32'd0);
        // R6 clear beats simultaneous sets
        host_cmd_wr = 1; cop_rsp_wr = 1; host_ctl_wr = 1; host_ctl_wdata = 2'b00; tick();
        chk("R6 clear wins", 32'(host_ctl_rdata), 32'd0);
        chk("R6 no irq on clear", 32'(cop_irq), 32'd0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            host_cmd_wr = ($urandom % 4) == 0;
            cop_cmd_rd  = ($urandom % 4) == 0;
            cop_rsp_wr  = ($urandom % 4) == 0;
            host_rsp_rd = ($urandom % 4) == 0;
            host_ctl_wr = ($urandom % 8) == 0;
            host_ctl_wdata = (($urandom % 6) == 0) ? 2'b00 : 2'(1 + $urandom % 3);
            host_cmd_data = 16'($urandom);
            cop_rsp_data  = 16'($urandom);
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule